// File: doc/BRIEF.md
# Keyed Software Pulse Trigger

This block lets software fire a single manual pulse on one of several output channels, while making a stray or accidental write very unlikely to do so. It watches byte writes to one register. A pulse is requested only after a four-byte unlock key has been written in order, and the byte that follows the key then selects the channel. That byte is a channel number counted from one.

Each write is a byte on `wr_data`, qualified by `wr_stb` for one clock. When the channel byte is valid, the block drives a one-hot trigger vector for exactly one clock. Bit n-1 of that vector goes high for channel n. An `armed` output shows that the key has been fully received and that the block is waiting for the channel byte. There are no timeouts: the state advances only on strobed writes. A later stage shapes the trigger into a pulse of any width.

Top module: `keyed_pulse_trigger`

## Requirements
- R1: The key is the byte sequence 0xDE, 0xAD, 0xBE, 0xEF. Each byte counts only in a cycle where `wr_stb` is high, and it is taken from `wr_data`.
- R2: After the full key, a strobed write of a value n with 1 <= n <= NUM_CH (6 by default) drives `trig` to the value 1 << (n-1). This happens in the cycle after the write's clock edge, and it lasts for exactly one cycle.
- R3: After the full key, a strobed write of 0 or of any value above NUM_CH drives no trigger and returns the block to idle. This holds even for 0xDE, which does not start a new key here.
- R4: During key entry, a strobed byte that is not the expected next key byte returns the block to idle. If that byte is 0xDE, it is accepted as the first key byte.
- R5: After a trigger, the block is idle, and the whole key must be written again before another channel write can fire.
- R6: `armed` is high from the cycle after the fourth key byte's edge until the cycle after the next strobed write's edge. It is low at all other times.
- R7: In cycles where `wr_stb` is low, the value on `wr_data` is ignored. The key progress and `armed` do not change, and `trig` stays zero.
- R8: A synchronous active-high `rst` clears the key progress, and it drives `trig` to zero and `armed` low on the next cycle.
- R9: At most one bit of `trig` is ever high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe for the trigger register, one cycle per byte |
| wr_data | input | DATA_W (8) | Written byte |
| trig | output | NUM_CH (6) | One-hot trigger, high for one cycle |
| armed | output | 1 | Key received, waiting for channel byte |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, six channels and the key 0xDEADBEEF. With six channels out of 256 byte codes, most values after the key are out of range, so the ignore-and-return path for zero, seven and high codes is easy to exercise. Because the key's first byte differs from every other key byte, a 0xDE written in the middle of the key is a clean test of the restart rule. The same bytes written after the key test the rule that no restart happens there.

// File: rtl/kpt_pkg.sv
package kpt_pkg;

  // How the key tracker moves on a given cycle
  typedef enum logic [1:0] {
    STEP_HOLD    = 2'd0,  // no strobe
    STEP_ADV     = 2'd1,  // expected key byte seen
    STEP_RESTART = 2'd2,  // mismatch, but byte equals first key byte
    STEP_CLEAR   = 2'd3   // mismatch or channel byte consumed
  } kpt_step_e;

endpackage

// File: rtl/kpt_key_tracker.sv
module kpt_key_tracker
  import kpt_pkg::*;
#(
  parameter int                        DATA_W  = 8,
  parameter int                        KEY_LEN = 4,
  parameter logic [KEY_LEN*DATA_W-1:0] KEY     = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              armed,
  output logic              chan_req
);

  localparam int SW    = $clog2(KEY_LEN + 1);
  localparam int SLOTS = 2 ** SW;

  logic [SW-1:0]    stage_q;
  logic [SW-1:0]    stage_d;
  logic [SLOTS-1:0] hit;
  logic             first_hit;
  logic             at_end;
  kpt_step_e        step;

  // Compare the byte with every key position in parallel; unused slots never match
  for (genvar i = 0; i < SLOTS; i++) begin : g_cmp
    if (i < KEY_LEN) begin : g_key
      assign hit[i] = (wr_data == KEY[(KEY_LEN-1-i)*DATA_W +: DATA_W]);
    end else begin : g_pad
      assign hit[i] = 1'b0;
    end
  end

  assign first_hit = hit[0];
  assign at_end    = (stage_q == SW'(KEY_LEN));
  assign chan_req  = wr_stb && at_end;

  always_comb begin
    if (!wr_stb)             step = STEP_HOLD;
    else if (at_end)         step = STEP_CLEAR;
    else if (hit[stage_q])   step = STEP_ADV;
    else if (first_hit)      step = STEP_RESTART;
    else                     step = STEP_CLEAR;
  end

  always_comb begin
    unique case (step)
      STEP_HOLD:    stage_d = stage_q;
      STEP_ADV:     stage_d = stage_q + SW'(1);
      STEP_RESTART: stage_d = SW'(1);
      default:      stage_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      armed   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      armed   <= (stage_d == SW'(KEY_LEN));
    end
  end

  // R6
  armed_tracks_stage_chk: assert property (@(posedge clk) disable iff (rst)
    armed == at_end);

  // R4
  stage_bound_chk: assert property (@(posedge clk) disable iff (rst)
    stage_q <= SW'(KEY_LEN));

endmodule

// File: rtl/kpt_chan_decode.sv
module kpt_chan_decode #(
  parameter int DATA_W = 8,
  parameter int NUM_CH = 6
) (
  input  logic [DATA_W-1:0] code,
  output logic [NUM_CH-1:0] onehot
);

  // Channel numbers start at one; zero and codes above NUM_CH select nothing
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign onehot[c] = (code == DATA_W'(c + 1));
  end

  // R9
  always_comb begin
    decode_onehot_chk: assert ($onehot0(onehot));
  end

endmodule

// File: rtl/keyed_pulse_trigger.sv
module keyed_pulse_trigger #(
  parameter int                        DATA_W  = 8,
  parameter int                        NUM_CH  = 6,
  parameter int                        KEY_LEN = 4,
  parameter logic [KEY_LEN*DATA_W-1:0] KEY     = 32'hDEAD_BEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] trig,
  output logic              armed
);

  logic              chan_req;
  logic [NUM_CH-1:0] sel_oh;

  kpt_key_tracker #(
    .DATA_W (DATA_W),
    .KEY_LEN(KEY_LEN),
    .KEY    (KEY)
  ) i_tracker (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .armed   (armed),
    .chan_req(chan_req)
  );

  kpt_chan_decode #(
    .DATA_W(DATA_W),
    .NUM_CH(NUM_CH)
  ) i_decode (
    .code  (wr_data),
    .onehot(sel_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) trig <= '0;
    else     trig <= chan_req ? sel_oh : '0;
  end

  // R9
  trig_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig));

  // R2
  trig_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (|trig) |=> (trig == '0));

  // R5
  trig_needs_armed_chk: assert property (@(posedge clk) disable iff (rst)
    (|trig) |-> ($past(armed) && !armed));

  // R6
  armed_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && wr_stb) |=> !armed);

  // R7
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> ($stable(armed) && trig == '0));

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (trig == '0 && !armed));

endmodule

// File: tb/test_keyed_pulse_trigger.sv
module test_keyed_pulse_trigger;

  localparam int NCH = 6;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_stb = 1'b0;
  logic [7:0]     wr_data = 8'h00;
  logic [NCH-1:0] trig;
  logic           armed;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit running = 1'b0;

  // reference model state
  int             m_pos = 0;      // number of key bytes received, 4 = armed
  logic [NCH-1:0] m_trig = '0;
  logic           m_armed = 1'b0;
  byte unsigned   key_q[$] = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};

  always #4 clk = ~clk;  // 125 MHz

  keyed_pulse_trigger i_keyed_pulse_trigger (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr_stb),
    .wr_data(wr_data),
    .trig   (trig),
    .armed  (armed)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_pos = 0; m_trig = '0; m_armed = 1'b0;              // R8
    end else begin
      m_trig = '0;
      if (wr_stb) begin
        if (m_pos == 4) begin
          if (wr_data >= 1 && wr_data <= NCH)
            m_trig = NCH'(1) << (wr_data - 1);              // R2
          m_pos = 0;                                        // R3, R5
        end else if (wr_data == key_q[m_pos]) begin
          m_pos = m_pos + 1;                                // R1
        end else if (wr_data == key_q[0]) begin
          m_pos = 1;                                        // R4
        end else begin
          m_pos = 0;
        end
      end                                                   // R7: no strobe, no change
      m_armed = (m_pos == 4);                               // R6
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (running) begin
      n_cmp++;
      if (trig !== m_trig) begin
        n_bad++;
        $display("FAIL R2 trig at cycle %0d: actual %b expected %b", cycles, trig, m_trig);
      end
      n_cmp++;
      if (armed !== m_armed) begin
        n_bad++;
        $display("FAIL R6 armed at cycle %0d: actual %b expected %b", cycles, armed, m_armed);
      end
    end
  end

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0; wr_data = 8'hEF;  // R7: junk data without strobe
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_data = 8'(i * 37 + 5);
    end
  endtask

  task automatic key();
    put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer than 20000", cycles);
      finish_run();
    end
  end

  initial begin
    running = 1'b1;
    repeat (3) @(negedge clk);               // R8 reset state compared
    rst = 1'b0;
    idle(2);
    // R1 R2: every channel in turn
    for (int ch = 1; ch <= NCH; ch++) begin
      key(); put(8'(ch)); idle(2);
    end
    // R3: out-of-range channel bytes, including 0xDE after the key
    key(); put(8'h00); idle(1);
    key(); put(8'h07); idle(1);
    key(); put(8'hFF); idle(1);
    key(); put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF); put(8'h02); idle(2);
    // R4: break at each key position, plain and with 0xDE restart
    put(8'h11); put(8'h01); idle(1);
    put(8'hDE); put(8'h00); put(8'hAD); put(8'h03); idle(1);
    put(8'hDE); put(8'hAD); put(8'h00); put(8'h04); idle(1);
    put(8'hDE); put(8'hAD); put(8'hBE); put(8'h00); put(8'h05); idle(1);
    put(8'hDE); put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF); put(8'h03); idle(1);
    put(8'hDE); put(8'hAD); put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF); put(8'h06); idle(1);
    put(8'hDE); put(8'hAD); put(8'hBE); put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF); put(8'h01); idle(1);
    // R5: a second channel byte right after a trigger fires nothing
    key(); put(8'h02); put(8'h03); idle(1);
    key(); put(8'h04); put(8'hDE); put(8'hAD); put(8'hBE); put(8'hEF); put(8'h05); idle(2);
    // R7 R6: long gaps between strobes, armed holds while waiting
    put(8'hDE); idle(5); put(8'hAD); idle(3); put(8'hBE); idle(4); put(8'hEF);
    idle(10); put(8'h06); idle(2);
    // back-to-back strobes without gaps
    @(negedge clk); wr_stb = 1'b1; wr_data = 8'hDE;
    @(negedge clk); wr_data = 8'hAD;
    @(negedge clk); wr_data = 8'hBE;
    @(negedge clk); wr_data = 8'hEF;
    @(negedge clk); wr_data = 8'h01;
    @(negedge clk); wr_data = 8'h02;
    @(negedge clk); wr_stb = 1'b0;
    idle(2);
    // R8: reset while armed and mid-key
    key(); @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    put(8'h03); idle(1);
    put(8'hDE); put(8'hAD); @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    put(8'hBE); put(8'hEF); put(8'h03); idle(1);
    // R8: strobe held with reset high is discarded
    @(negedge clk); rst = 1'b1; wr_stb = 1'b1; wr_data = 8'hDE;
    @(negedge clk); rst = 1'b0; wr_stb = 1'b0;
    put(8'hAD); put(8'hBE); put(8'hEF); put(8'h02); idle(3);
    finish_run();
  end

endmodule